// File: doc/BRIEF.md
# Unary Element Driver with Rotating Thermometer Mapping

This block feeds a bank of 32 one-bit conversion elements of equal weight, as found in the digital back end of a multi-level sigma-delta converter. Because every element has the same weight, the analog sum of the bank has 33 levels, from 0 to 32 active elements. The value is carried only as a count of active elements, and no signed binary number appears anywhere on the data path.

In the default serial mode a one-bit modulator stream enters a 32-stage shift register that drives the elements directly. Each input bit passes through every element once over 32 samples. The number of active elements is therefore the moving sum of the last 32 input bits, so element matching and a boxcar filter come from the same structure. When the mode input is high, the block instead takes a 5-bit binary word N on each sample. It lights a contiguous run of N elements. The start of each run follows on from the end of the previous one, so the load is spread over the whole bank.

The block updates only on a sample-enable pulse. It also reports the number of active elements as a binary count.

Top module: `unary_element_driver`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears the element outputs and the active count to zero, selects serial mode and sets the rotation start to element 0.
- R2: In serial mode each sample moves the pattern up by one element: element i takes the old value of element i-1, and element 0 takes `serialBit`.
- R3: In serial mode `activeCount` equals the sum of the last 32 serial bits taken since the last history clear. It reaches 32 for a long run of ones.
- R4: While `sampleEn` is low, `elements` and `activeCount` hold their values whatever the other inputs do.
- R5: In parallel mode a sample with word N (0 to 31) lights exactly N elements. They form a contiguous run that starts at the current start element and wraps from element 31 to element 0. `activeCount` equals N.
- R6: After each parallel sample the start element advances by N modulo 32. On entry to parallel mode the start element is 0.
- R7: `parallelMode` is sampled only when `sampleEn` is high. A sample taken with a mode different from the current one clears the serial history first, so after a return to serial mode the count equals only the bits taken since that return.
- R8: `activeCount` always equals the number of ones on `elements`.
- R9: A sample taken at a rising edge with `sampleEn` high appears on the outputs directly after that same edge, which is one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleEn | input | 1 | One-clock sample strobe |
| serialBit | input | 1 | One-bit modulator stream (serial mode) |
| wordIn | input | 5 | Binary modulator word N (parallel mode) |
| parallelMode | input | 1 | 0 selects serial mode, 1 selects parallel mode |
| elements | output | 32 | Drive for the equally weighted elements |
| activeCount | output | 6 | Number of active elements |

## Verification
Alternating, sparse and burst serial streams show whether bits move one element per sample and whether the moving sum counts correctly. A run of all ones shows whether the count saturates at exactly 32. Sequences of parallel words, including 0 and 31, show whether the runs have the right length and wrap across element 31, and whether the start element advances by the word value. Mode flips with and without a sample strobe show whether the mode is latched only on a sample and whether old history is discarded.

// File: rtl/ued_pkg.sv
package ued_pkg;
  typedef struct packed {
    logic shiftEn;
    logic rotEn;
    logic clearHist;
  } ued_strobe_t;
endpackage

// File: rtl/ued_ctrl.sv
module ued_ctrl
  import ued_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleEn,
  input  logic        parallelMode,
  output ued_strobe_t strobes
);
  logic modeReg;

  always_ff @(posedge clk) begin
    if (rst) modeReg <= 1'b0;
    else if (sampleEn) modeReg <= parallelMode;
  end

  always_comb begin
    strobes.shiftEn   = sampleEn && !parallelMode;
    strobes.rotEn     = sampleEn && parallelMode;
    strobes.clearHist = sampleEn && (parallelMode != modeReg);
  end

  // R7: the latched mode moves only on a sample
  assert_mode_latched_R7: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |=> $stable(modeReg));
  // R7: a clear strobe can appear only together with a sample
  assert_clear_on_sample_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.clearHist |-> (strobes.shiftEn || strobes.rotEn));
endmodule

// File: rtl/ued_datapath.sv
module ued_datapath
  import ued_pkg::*;
#(
  parameter int NUM_ELEM = 32,
  parameter int WORD_W   = 5,
  localparam int PTR_W   = $clog2(NUM_ELEM),
  localparam int CNT_W   = $clog2(NUM_ELEM + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  ued_strobe_t         strobes,
  input  logic                serialBit,
  input  logic [WORD_W-1:0]   wordIn,
  output logic [NUM_ELEM-1:0] elements,
  output logic [CNT_W-1:0]    activeCount
);
  logic [NUM_ELEM-1:0] shiftReg;
  logic [NUM_ELEM-1:0] thermo;
  logic [NUM_ELEM-1:0] rotated;
  logic [NUM_ELEM-1:0] shiftNext;
  logic [PTR_W-1:0]    ptr;
  logic [PTR_W-1:0]    startPtr;
  logic [CNT_W-1:0]    countNext;

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_thermo
    assign thermo[g] = (int'(wordIn) > g);
  end

  always_comb begin
    startPtr = strobes.clearHist ? '0 : ptr;
    rotated  = (thermo << startPtr) | (thermo >> (NUM_ELEM - int'(startPtr)));
    if (strobes.clearHist) begin
      shiftNext = {{(NUM_ELEM-1){1'b0}}, serialBit};
      countNext = CNT_W'(serialBit);
    end else begin
      shiftNext = {shiftReg[NUM_ELEM-2:0], serialBit};
      countNext = activeCount + CNT_W'(serialBit) - CNT_W'(shiftReg[NUM_ELEM-1]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg    <= '0;
      ptr         <= '0;
      elements    <= '0;
      activeCount <= '0;
    end else if (strobes.shiftEn) begin
      shiftReg    <= shiftNext;
      elements    <= shiftNext;
      activeCount <= countNext;
    end else if (strobes.rotEn) begin
      shiftReg    <= '0;
      elements    <= rotated;
      ptr         <= startPtr + PTR_W'(wordIn);
      activeCount <= CNT_W'(wordIn);
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (elements == '0 && activeCount == '0));
  assert_serial_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (strobes.shiftEn && !strobes.clearHist) |=>
      (elements[NUM_ELEM-1:1] == $past(elements[NUM_ELEM-2:0]) && elements[0] == $past(serialBit)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(strobes.shiftEn || strobes.rotEn) |=> ($stable(elements) && $stable(activeCount)));
  assert_par_count_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.rotEn |=> (activeCount == CNT_W'($past(wordIn))));
  assert_ptr_advance_R6: assert property (@(posedge clk) disable iff (rst)
    (strobes.rotEn && !strobes.clearHist) |=> (ptr == $past(ptr) + PTR_W'($past(wordIn))));
  assert_count_match_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(elements) == int'(activeCount));
endmodule

// File: rtl/unary_element_driver.sv
module unary_element_driver #(
  parameter int NUM_ELEM = 32,
  parameter int WORD_W   = 5,
  localparam int CNT_W   = $clog2(NUM_ELEM + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleEn,
  input  logic                serialBit,
  input  logic [WORD_W-1:0]   wordIn,
  input  logic                parallelMode,
  output logic [NUM_ELEM-1:0] elements,
  output logic [CNT_W-1:0]    activeCount
);
  ued_pkg::ued_strobe_t strobes;

  ued_ctrl ctrl_i (
    .clk(clk), .rst(rst), .sampleEn(sampleEn),
    .parallelMode(parallelMode), .strobes(strobes)
  );

  ued_datapath #(.NUM_ELEM(NUM_ELEM), .WORD_W(WORD_W)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .serialBit(serialBit),
    .wordIn(wordIn), .elements(elements), .activeCount(activeCount)
  );
endmodule

// File: tb/unary_element_driver_tb.sv
module unary_element_driver_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sampleEn = 1'b0;
  logic        serialBit = 1'b0;
  logic [4:0]  wordIn = '0;
  logic        parallelMode = 1'b0;
  logic [31:0] elements;
  logic [5:0]  activeCount;

  int tests = 0;
  int fails = 0;

  logic [31:0] mHist;
  logic [31:0] mElem;
  logic [4:0]  mPtr;
  logic        mMode;
  int          mCount;

  always #2 clk = ~clk;

  unary_element_driver dut_i (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .serialBit(serialBit),
    .wordIn(wordIn), .parallelMode(parallelMode),
    .elements(elements), .activeCount(activeCount)
  );

  // vector: {parallelMode, serialBit, word}
  localparam logic [6:0] VEC [24] = '{
    7'b0_1_00000, 7'b0_0_00000, 7'b0_1_00000, 7'b0_1_00000,
    7'b0_0_00000, 7'b0_0_00000, 7'b0_1_00000, 7'b0_1_00000,
    7'b0_1_00000, 7'b0_0_00000, 7'b1_0_00011, 7'b1_0_00101,
    7'b1_0_00000, 7'b1_0_11111, 7'b1_0_11111, 7'b1_0_00001,
    7'b1_0_10000, 7'b1_0_01111, 7'b0_1_00000, 7'b0_1_00000,
    7'b0_0_00000, 7'b1_0_00111, 7'b1_0_11000, 7'b0_0_00000
  };

  task automatic check(input string req, input logic [31:0] expE, input int expC);
    tests++;
    if (elements !== expE || int'(activeCount) != expC) begin
      fails++;
      $display("FAIL %s: elements=%h count=%0d expected elements=%h count=%0d",
               req, elements, activeCount, expE, expC);
    end
  endtask

  task automatic modelReset();
    mHist = '0; mElem = '0; mPtr = '0; mMode = 1'b0; mCount = 0;
  endtask

  task automatic sample(input logic par, input logic b, input logic [4:0] w);
    @(negedge clk);
    parallelMode = par; serialBit = b; wordIn = w; sampleEn = 1'b1;
    if (par != mMode) begin mHist = '0; mPtr = '0; end
    mMode = par;
    if (!par) begin
      mHist = {mHist[30:0], b};
      mElem = mHist;
      mCount = $countones(mHist);
    end else begin
      mHist = '0;
      mElem = '0;
      for (int k = 0; k < int'(w); k++) mElem[(int'(mPtr) + k) % 32] = 1'b1;
      mCount = int'(w);
      mPtr = 5'((int'(mPtr) + int'(w)) % 32);
    end
    @(negedge clk);
    sampleEn = 1'b0;
  endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", 32'h0, 0);

    // table walk: serial shifts (R2, R3), parallel runs and pointer (R5, R6), mode flips (R7)
    foreach (VEC[i]) begin
      sample(VEC[i][6], VEC[i][5], VEC[i][4:0]);
      check(VEC[i][6] ? "R5/R6 parallel run" : "R2/R3 serial shift", mElem, mCount);
    end

    // R9: output unchanged just before edge, new value right after
    @(negedge clk);
    parallelMode = 1'b1; wordIn = 5'd9; sampleEn = 1'b1;
    check("R9 before sampling edge", mElem, mCount);
    @(posedge clk); #1;
    sampleEn = 1'b0;
    mElem = '0;
    for (int k = 0; k < 9; k++) mElem[k] = 1'b1;
    mCount = 9; mPtr = 5'd9; mMode = 1'b1; mHist = '0;
    check("R9 one-clock latency", mElem, mCount);

    // R4: inputs churn without sampleEn
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      parallelMode = c[0]; serialBit = ~c[1]; wordIn = 5'(c * 7);
    end
    @(negedge clk);
    check("R4 hold between samples", mElem, mCount);

    // R7: mode flip without strobe is ignored; next parallel sample continues from pointer 9
    parallelMode = 1'b0;
    repeat (3) @(negedge clk);
    sample(1'b1, 1'b0, 5'd4);
    check("R7 mode ignored without sample, R6 start 9", mElem, mCount);

    // R7: return to serial clears history
    sample(1'b0, 1'b1, 5'd0);
    check("R7 history cleared on mode change", 32'h1, 1);

    // R3: long run of ones saturates at 32
    for (int k = 0; k < 40; k++) sample(1'b0, 1'b1, 5'd0);
    check("R3 all ones gives 32", 32'hFFFF_FFFF, 32);
    sample(1'b0, 1'b0, 5'd0);
    check("R3 oldest one drops out", mElem, 31);

    // R6: wrap across element 31
    sample(1'b1, 1'b0, 5'd30);
    sample(1'b1, 1'b0, 5'd5);
    check("R6 run wraps from 31 to 0", 32'hC000_0007, 5);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    modelReset();
    check("R1 reset mid-run", 32'h0, 0);
    sample(1'b1, 1'b0, 5'd2);
    check("R1 pointer back to 0 after reset", 32'h3, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule